// File: doc/BRIEF.md
# Hit-List Formatting Readout Controller

This block terminates a chain of front-end strip chips and turns each event's serial record stream into a packet of strip addresses. A trigger starts an event. For each configured chip the block then reads one flag bit. A flag of 0 means that chip saw nothing. A flag of 1 is followed by 64 channel bits, and each set channel becomes one address word. Chips without hits therefore cost one bit and produce no output, which completes zero suppression.

While the event is being parsed, the block counts how long the layer's Fast-OR is high. It closes the packet with a trailer that carries the hit count and this time-over-threshold value.

Finished packets wait in an internal word FIFO. Several controllers share one output line and pass a token between them. A controller sends only while it holds the token, sends one packet per grant, and then hands the token on. If no complete packet is waiting when the token arrives, it sends a single empty-packet word instead.

Back-pressure rules:
- The serial input is accepted on `in_valid && in_ready`.
- The trigger is accepted on `trig_valid && trig_ready`.
- The output is accepted on `tx_valid && tx_ready`. Once `tx_valid` is raised, it and `tx_data` stay put until the word is accepted.

Top module: `hitlist_ctrl`

## Requirements
- R1: After reset, `tx_valid`, `token_out` and `in_ready` are 0 and `trig_ready` is 1.
- R2: After an accepted trigger, the block reads `cfg_chips` records (1 to 28). Each record is one flag bit: 0 = no hits, or 1 followed by 64 channel bits with channel 0 first. `in_ready` is 0 whenever no event is being parsed.
- R3: Each set channel bit yields one address word: bits [20:19] = 2'b01, bits [18:11] = 0, bits [10:6] = chip index, bits [5:0] = channel index. Words go out in increasing address order, and hit-free chips yield no word.
- R4: Each packet ends with one trailer word: bits [20:19] = 2'b10, bits [18:11] = time-over-threshold, bits [10:0] = number of address words. `tx_last` is 1 on this word.
- R5: Time-over-threshold is the number of clock edges at which `fast_or` is 1 while the event is being parsed. Parsing lasts from the edge after trigger acceptance to the edge that accepts the last record bit. The count saturates at 255.
- R6: `tx_valid` is 1 only while the token is held. The token is taken by a one-cycle `token_in` pulse. After the last word of the granted packet is accepted, `token_out` is 1 for exactly one cycle, in the next cycle.
- R7: If the token arrives while no complete packet is buffered, one word with bits [20:19] = 2'b11 and all other bits 0 is sent with `tx_last` = 1, and then the token is passed on.
- R8: Complete packets are buffered, and each grant sends exactly one packet, oldest first.
- R9: `trig_ready` is 0 while an event is being parsed and while the FIFO is full. It returns to 1 once a grant drains space.
- R10: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_data` is unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_chips | input | 5 | Number of chips in the chain, 1 to 28 |
| trig_valid | input | 1 | Event trigger request |
| trig_ready | output | 1 | Trigger can be accepted |
| fast_or | input | 1 | Layer Fast-OR level |
| in_valid | input | 1 | Serial record bit valid |
| in_ready | output | 1 | Serial record bit accepted |
| in_bit | input | 1 | Serial record bit |
| token_in | input | 1 | One-cycle token grant from the previous controller |
| token_out | output | 1 | One-cycle token hand-off to the next controller |
| tx_valid | output | 1 | Output word valid |
| tx_ready | input | 1 | Output word accepted |
| tx_data | output | 21 | Output word (address, trailer or empty header) |
| tx_last | output | 1 | Current word closes the packet |

## Verification
The assertions take the input side on trust in four ways:
- `token_in` pulses only while this controller does not already hold the token.
- `cfg_chips` stays within 1 to 28 and does not change during an event.
- Every event fits in the FIFO, so a packet's trailer is always written before the FIFO fills.
- Once `tx_valid` is up, `tx_ready` only needs to be eventually high for progress.

The stimulus respects these assumptions. It grants the token only after the previous hand-off has been seen, changes `cfg_chips` only between events, and builds events of at most eight words against a 16-word FIFO. It presents the record bits back to back, so the expected time-over-threshold equals the number of bits fed while `fast_or` is high.

// File: rtl/hitlist_pkg.sv
package hitlist_pkg;
  // Output word kind, carried in the two top bits of every word.
  typedef enum logic [1:0] {
    W_NONE  = 2'b00,
    W_ADDR  = 2'b01,
    W_TRAIL = 2'b10,
    W_EMPTY = 2'b11
  } wkind_e;
endpackage

// File: rtl/hit_parser.sv
module hit_parser
  import hitlist_pkg::*;
#(
  parameter int CHIP_W = 5,
  parameter int CHAN_W = 6,
  parameter int TOT_W  = 8,
  localparam int ADDR_W = CHIP_W + CHAN_W,
  localparam int WORD_W = 2 + TOT_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHIP_W-1:0] cfg_chips,
  input  logic              trig_valid,
  output logic              trig_ready,
  input  logic              fast_or,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit,
  input  logic              fifo_full,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_data,
  output logic              pkt_done
);
  typedef enum logic [1:0] {P_IDLE, P_FLAG, P_CHAN, P_TRAIL} pst_e;
  localparam logic [CHIP_W-1:0] ONE_C = CHIP_W'(1);
  localparam logic [CHAN_W-1:0] ONE_H = CHAN_W'(1);
  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
  localparam logic [TOT_W-1:0]  ONE_T = TOT_W'(1);

  pst_e              st;
  logic [CHIP_W-1:0] chip;
  logic [CHAN_W-1:0] chan;
  logic [ADDR_W-1:0] hits;
  logic [TOT_W-1:0]  tot;
  logic              parsing, take, last_chip;

  assign parsing    = (st == P_FLAG) || (st == P_CHAN);
  assign trig_ready = (st == P_IDLE) && !fifo_full;
  assign in_ready   = parsing && !fifo_full;
  assign take       = in_valid && in_ready;
  assign last_chip  = (chip == cfg_chips - ONE_C);
  assign pkt_done   = (st == P_TRAIL) && !fifo_full;
  assign wr_en      = (st == P_CHAN && take && in_bit) || pkt_done;

  always_comb begin
    if (st == P_TRAIL) wr_data = {W_TRAIL, tot, hits};
    else               wr_data = {W_ADDR, {TOT_W{1'b0}}, chip, chan};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= P_IDLE;
      chip <= '0;
      chan <= '0;
      hits <= '0;
      tot  <= '0;
    end else begin
      if (parsing && fast_or && tot != '1) tot <= tot + ONE_T;
      case (st)
        P_IDLE: if (trig_valid && trig_ready) begin
          st   <= P_FLAG;
          chip <= '0;
          hits <= '0;
          tot  <= '0;
        end
        P_FLAG: if (take) begin
          if (in_bit) begin
            st   <= P_CHAN;
            chan <= '0;
          end else if (last_chip) st <= P_TRAIL;
          else chip <= chip + ONE_C;
        end
        P_CHAN: if (take) begin
          chan <= chan + ONE_H;
          if (in_bit) hits <= hits + ONE_A;
          if (chan == '1) begin
            if (last_chip) st <= P_TRAIL;
            else begin
              st   <= P_FLAG;
              chip <= chip + ONE_C;
            end
          end
        end
        default: if (!fifo_full) st <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/word_fifo.sv
module word_fifo #(
  parameter int W     = 21,
  parameter int DEPTH = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam logic [AW-1:0] LAST_P = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULL_C = (AW + 1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd, wr;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == FULL_C);
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd  <= '0;
      wr  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wr <= (wr == LAST_P) ? '0 : wr + 1'b1;
      if (do_pop)  rd <= (rd == LAST_P) ? '0 : rd + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/tok_tx.sv
module tok_tx
  import hitlist_pkg::*;
#(
  parameter int WORD_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              token_in,
  output logic              token_out,
  input  logic              pkt_avail,
  input  logic [WORD_W-1:0] head,
  input  logic              empty,
  output logic              pop,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_last
);
  typedef enum logic [1:0] {T_IDLE, T_DATA, T_EMPTY} tst_e;
  tst_e   st;
  wkind_e kind;
  logic   done;

  assign tx_data  = (st == T_EMPTY) ? {W_EMPTY, {(WORD_W-2){1'b0}}} : head;
  assign tx_valid = (st == T_EMPTY) || (st == T_DATA && !empty);
  assign kind     = wkind_e'(tx_data[WORD_W-1 -: 2]);
  assign tx_last  = tx_valid && (kind == W_TRAIL || kind == W_EMPTY);
  assign pop      = (st == T_DATA) && tx_valid && tx_ready;
  assign done     = tx_valid && tx_ready && tx_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= T_IDLE;
      token_out <= 1'b0;
    end else begin
      token_out <= 1'b0;
      case (st)
        T_IDLE:  if (token_in) st <= pkt_avail ? T_DATA : T_EMPTY;
        default: if (done) begin
          st        <= T_IDLE;
          token_out <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/hitlist_ctrl.sv
module hitlist_ctrl
  import hitlist_pkg::*;
#(
  parameter int MAX_CHIPS = 28,
  parameter int CHANS     = 64,
  parameter int TOT_W     = 8,
  parameter int DEPTH     = 32,
  localparam int CHIP_W   = $clog2(MAX_CHIPS),
  localparam int CHAN_W   = $clog2(CHANS),
  localparam int ADDR_W   = CHIP_W + CHAN_W,
  localparam int WORD_W   = 2 + TOT_W + ADDR_W,
  localparam int PC_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHIP_W-1:0] cfg_chips,
  input  logic              trig_valid,
  output logic              trig_ready,
  input  logic              fast_or,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit,
  input  logic              token_in,
  output logic              token_out,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_last
);
  logic              fifo_push, fifo_pop, fifo_full, fifo_empty, pkt_done;
  logic [WORD_W-1:0] wr_data, head;
  logic [PC_W-1:0]   pkt_cnt;
  logic              trail_out;

  hit_parser #(.CHIP_W(CHIP_W), .CHAN_W(CHAN_W), .TOT_W(TOT_W)) u_parse (
    .clk, .rst_n, .cfg_chips, .trig_valid, .trig_ready, .fast_or,
    .in_valid, .in_ready, .in_bit, .fifo_full,
    .wr_en(fifo_push), .wr_data, .pkt_done
  );

  word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk, .rst_n, .push(fifo_push), .wdata(wr_data), .pop(fifo_pop),
    .rdata(head), .full(fifo_full), .empty(fifo_empty)
  );

  // Complete packets held in the FIFO.
  assign trail_out = fifo_pop && (wkind_e'(head[WORD_W-1 -: 2]) == W_TRAIL);

  always_ff @(posedge clk) begin
    if (!rst_n) pkt_cnt <= '0;
    else if (pkt_done && !trail_out) pkt_cnt <= pkt_cnt + 1'b1;
    else if (!pkt_done && trail_out) pkt_cnt <= pkt_cnt - 1'b1;
  end

  tok_tx #(.WORD_W(WORD_W)) u_tx (
    .clk, .rst_n, .token_in, .token_out, .pkt_avail(pkt_cnt != '0),
    .head, .empty(fifo_empty), .pop(fifo_pop),
    .tx_valid, .tx_ready, .tx_data, .tx_last
  );
endmodule

// File: rtl/hitlist_ctrl_chk.sv
module hitlist_ctrl_chk
  import hitlist_pkg::*;
#(
  parameter int WORD_W = 21,
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              token_in,
  input logic              token_out,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [WORD_W-1:0] tx_data,
  input logic              tx_last,
  input logic              trig_valid,
  input logic              trig_ready,
  input logic              fifo_full
);
  logic              held, have_prev, hs;
  logic [ADDR_W-1:0] prev;

  assign hs = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held      <= 1'b0;
      have_prev <= 1'b0;
      prev      <= '0;
    end else begin
      if (token_in) held <= 1'b1;
      else if (hs && tx_last) held <= 1'b0;
      if (hs && tx_last) have_prev <= 1'b0;
      else if (hs && tx_data[WORD_W-1 -: 2] == W_ADDR) begin
        have_prev <= 1'b1;
        prev      <= tx_data[ADDR_W-1:0];
      end
    end
  end

  assert_tx_only_with_token_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> held);
  assert_token_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && tx_last) |=> token_out);
  assert_token_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    token_out |=> !token_out);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  assert_trig_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && trig_ready) |=> !trig_ready);
  assert_full_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !trig_ready);
  assert_addr_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && have_prev && tx_data[WORD_W-1 -: 2] == W_ADDR) |-> (tx_data[ADDR_W-1:0] > prev));
endmodule

bind hitlist_ctrl hitlist_ctrl_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .token_in(token_in), .token_out(token_out),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
  .trig_valid(trig_valid), .trig_ready(trig_ready), .fifo_full(fifo_full)
);

// File: tb/tb_hitlist_ctrl.sv
module tb_hitlist_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_chips = 5'd1;
  logic        trig_valid = 1'b0, fast_or = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
  logic        token_in = 1'b0, tx_ready = 1'b0;
  logic        trig_ready, in_ready, token_out, tx_valid, tx_last;
  logic [20:0] tx_data;

  int          n_chk = 0, n_fail = 0, pend = 0;
  logic [20:0] exp_q[$];
  logic [63:0] pat[28];

  always #5 clk = ~clk;

  hitlist_ctrl #(.DEPTH(16)) dut (
    .clk, .rst_n, .cfg_chips, .trig_valid, .trig_ready, .fast_or,
    .in_valid, .in_ready, .in_bit, .token_in, .token_out,
    .tx_valid, .tx_ready, .tx_data, .tx_last
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    in_valid = 1'b1;
    in_bit   = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Driver: feeds one event from pat[] and queues the expected packet.
  task automatic run_event(input int nch, input bit fo);
    int bits = 0;
    int hits = 0;
    int tot;
    cfg_chips  = nch[4:0];
    trig_valid = 1'b1;
    fast_or    = fo;
    while (!trig_ready) @(negedge clk);
    @(negedge clk);
    trig_valid = 1'b0;
    chk(trig_ready == 1'b0, "R9 busy", 32'(trig_ready), 0);
    for (int c = 0; c < nch; c++) begin
      if (pat[c] == 64'd0) begin
        drive_bit(1'b0);
        bits++;
      end else begin
        drive_bit(1'b1);
        bits++;
        for (int h = 0; h < 64; h++) begin
          drive_bit(pat[c][h]);
          bits++;
          if (pat[c][h]) begin
            exp_q.push_back({2'b01, 8'd0, 5'(c), 6'(h)});
            hits++;
          end
        end
      end
    end
    fast_or = 1'b0;
    tot = fo ? ((bits > 255) ? 255 : bits) : 0;
    exp_q.push_back({2'b10, 8'(tot), 11'(hits)});
    pend++;
    @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: grants the token and compares each output word with the queue.
  task automatic grant(input bit bp);
    int k = 0;
    if (pend == 0) exp_q.push_back({2'b11, 19'd0});
    else pend--;
    token_in = 1'b1;
    @(negedge clk);
    token_in = 1'b0;
    for (int it = 0; it < 3000; it++) begin
      tx_ready = bp ? ((k % 3) != 0) : 1'b1;
      k++;
      if (tx_valid && tx_ready) begin
        logic [20:0] e;
        logic        lst;
        e   = exp_q.pop_front();
        lst = tx_last;
        chk(tx_data == e, (e[20:19] == 2'b01) ? "R3 addr" : (e[20:19] == 2'b10) ? "R4 trailer" : "R7 empty",
            32'(tx_data), 32'(e));
        chk(lst == (e[20:19] != 2'b01), "R4 last flag", 32'(lst), 32'(e[20:19] != 2'b01));
        @(negedge clk);
        if (lst) begin
          chk(token_out == 1'b1, "R6 token_out", 32'(token_out), 1);
          chk(tx_valid == 1'b0, "R6 idle after pass", 32'(tx_valid), 0);
          break;
        end
      end else if (tx_valid) begin
        logic [20:0] d;
        d = tx_data;
        @(negedge clk);
        chk(tx_valid && tx_data == d, "R10 hold", 32'(tx_data), 32'(d));
      end else begin
        @(negedge clk);
      end
    end
    tx_ready = 1'b0;
    @(negedge clk);
    chk(token_out == 1'b0, "R6 single pulse", 32'(token_out), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R6 actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 28; i++) pat[i] = 64'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_valid == 1'b0, "R1 tx_valid", 32'(tx_valid), 0);
    chk(token_out == 1'b0, "R1 token_out", 32'(token_out), 0);
    chk(trig_ready == 1'b1, "R1 trig_ready", 32'(trig_ready), 1);
    chk(in_ready == 1'b0, "R1 R2 in_ready", 32'(in_ready), 0);

    // R2 R3 R4 R5: three chips, middle one hit on channels 0, 5, 63
    pat[1] = 64'h8000_0000_0000_0021;
    run_event(3, 1'b1);
    grant(1'b0);

    // R7: token with nothing buffered
    grant(1'b0);

    // R2 R3: full 28-chip chain, hits on first and last chip, no Fast-OR
    for (int i = 0; i < 28; i++) pat[i] = 64'd0;
    pat[0]  = 64'h2;
    pat[27] = 64'h400;
    run_event(28, 1'b0);
    grant(1'b1);

    // R5: time-over-threshold saturation (260 bits parsed)
    for (int i = 0; i < 28; i++) pat[i] = 64'd0;
    for (int i = 0; i < 4; i++) pat[i] = 64'd1 << (i * 3);
    run_event(4, 1'b1);
    grant(1'b1);

    // R4: chips with no hits give only a trailer
    for (int i = 0; i < 28; i++) pat[i] = 64'd0;
    run_event(2, 1'b1);
    grant(1'b0);

    // R8 R9: two 8-word packets fill the 16-word FIFO
    pat[0] = 64'h7f;
    run_event(1, 1'b1);
    run_event(1, 1'b0);
    trig_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk(trig_ready == 1'b0, "R9 full blocks trigger", 32'(trig_ready), 0);
    trig_valid = 1'b0;
    grant(1'b0);
    chk(trig_ready == 1'b1, "R9 ready after drain", 32'(trig_ready), 1);
    grant(1'b1);
    chk(exp_q.size() == 0, "R8 all packets sent", 32'(exp_q.size()), 0);
    chk(in_ready == 1'b0, "R2 idle in_ready", 32'(in_ready), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule